// File: doc/BRIEF.md
# Device Power State Controller

This block keeps the power state of one bus device and lets configuration software see and change it through two 32-bit words in configuration space. These two words make up the 8-byte power-management capability. The first word is read-only and reports what the device can do. The second word is the control/status word: software writes a requested state into it and reads the current state back from it.

There are four states, ordered from full power to off: D0 (on), D1 and D2 (intermediate, lower power) and D3 (off). A higher number means less power. D1 and D2 are optional and set by parameters.

The state machine accepts a request in only two cases: the target is deeper than the current state, or the target is D0. A request that breaks this rule, or that names a state the device does not support, is dropped. The named transitions are:

- DEEPEN: to a higher-numbered supported state.
- RETURN: from any state to D0.
- HOLD: every dropped request, and every cycle without a write.

Each state drives its own outputs. The function-disable output is active in every state except D0, and the clock-gate output is active in D2 and D3. In D1 and D2 a local wake source can latch a wake status bit when wake is enabled. That bit drives an active-low, open-drain style wake line.

Top module: `pmc_ctrl`

## Requirements
- R1: After reset the state is D0, wake enable is 0, wake status is 0, `wake_n` is 1, and the control/status word reads 0.
- R2: The capability word (`cfg_sel`=0) reads `CAP_ID` in bits 7:0, `NEXT_PTR` in bits 15:8, D1 support in bit 16, D2 support in bit 17 and wake support in bit 18. All other bits read 0.
- R3: A control/status write (`cfg_sel`=1) whose bits 1:0 name a supported state deeper than the current one (encoding D0=0, D1=1, D2=2, D3=3) moves the state there at the next clock edge. The new state is readable in bits 1:0 and on `pwr_state`.
- R4: A write with bits 1:0 equal to 0 returns the device to D0 from any state.
- R5: A write that names a shallower state other than D0, or the current state, leaves the state unchanged. The state also never changes without a control/status write.
- R6: A write that names D1 or D2 while that state is not supported by parameter is ignored, and the state stays unchanged.
- R7: `func_disable` is 1 in D1, D2 and D3. `clk_gate` is 1 in D2 and D3. Both are 0 in D0.
- R8: Wake status (control/status bit 15) is set at the clock edge after `wake_src` is high. This happens only while the state is D1 or D2, wake enable is 1 and wake is supported. It is never set in D0 or D3.
- R9: `wake_n` is 0 exactly while wake status is 1.
- R10: Writing 1 to bit 15 clears wake status. Writing 0 to bit 15 leaves it unchanged.
- R11: Any transition into D0 clears wake status.
- R12: Wake enable is control/status bit 8. Every control/status write loads it, and it reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Word select: 0 capability, 1 control/status |
| cfg_wdata | input | DATA_W | Write data |
| cfg_rdata | output | DATA_W | Read data of the selected word |
| wake_src | input | 1 | Local wake source |
| pwr_state | output | 2 | Current power state |
| clk_gate | output | 1 | Clock-gate enable |
| func_disable | output | 1 | Function-disable |
| wake_n | output | 1 | Wake event line, active low |

## Verification
The assertions check the following on every cycle:

- Each state change is either a deepening or a return to D0.
- The state never moves without a control/status write, and never enters an unsupported state.
- D0 is quiet on all outputs.
- A falling `wake_n` always has a qualifying wake cause in the cycle before, and a release always follows a write-one-to-clear or a return to D0.

The bench's scenarios are what show the rest:

- the capability word contents and the wake-enable readback,
- that writing 0 to the status bit leaves it alone,
- that a wake source in D0 or D3, or with wake disabled, has no effect,
- that wake status survives a move from D1 into D3.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        PS_D0 = 2'd0,
        PS_D1 = 2'd1,
        PS_D2 = 2'd2,
        PS_D3 = 2'd3
    } pstate_e;

    localparam logic SEL_CAP  = 1'b0;
    localparam logic SEL_CTRL = 1'b1;

    localparam int STATE_LSB    = 0;
    localparam int WAKE_EN_BIT  = 8;
    localparam int WAKE_ST_BIT  = 15;
    localparam int CAP_ID_LSB   = 0;
    localparam int CAP_NXT_LSB  = 8;
    localparam int CAP_D1_BIT   = 16;
    localparam int CAP_D2_BIT   = 17;
    localparam int CAP_WAKE_BIT = 18;

endpackage

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
#(
    parameter bit D1_OK = 1'b1,
    parameter bit D2_OK = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_code,
    output pstate_e    state_q,
    output logic       to_d0,
    output logic       clk_gate,
    output logic       func_dis
);

    pstate_e state_d;
    pstate_e req_e;

    assign req_e = pstate_e'(req_code);
    assign to_d0 = (state_d == PS_D0);

    // Next state: only deepening moves or a return to D0 are taken
    always_comb begin
        state_d = state_q;
        if (req_valid) begin
            unique case (state_q)
                PS_D0: begin
                    if ((req_e == PS_D1 && D1_OK) ||
                        (req_e == PS_D2 && D2_OK) ||
                        (req_e == PS_D3))
                        state_d = req_e;
                end
                PS_D1: begin
                    if ((req_e == PS_D0) ||
                        (req_e == PS_D2 && D2_OK) ||
                        (req_e == PS_D3))
                        state_d = req_e;
                end
                PS_D2: begin
                    if (req_e == PS_D0 || req_e == PS_D3)
                        state_d = req_e;
                end
                PS_D3: begin
                    if (req_e == PS_D0)
                        state_d = req_e;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PS_D0;
        else
            state_q <= state_d;
    end

    // Per-state outputs
    always_comb begin
        clk_gate = 1'b0;
        func_dis = 1'b0;
        unique case (state_q)
            PS_D0: begin
                clk_gate = 1'b0;
                func_dis = 1'b0;
            end
            PS_D1: begin
                clk_gate = 1'b0;
                func_dis = 1'b1;
            end
            PS_D2: begin
                clk_gate = 1'b1;
                func_dis = 1'b1;
            end
            PS_D3: begin
                clk_gate = 1'b1;
                func_dis = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pmc_wake.sv
module pmc_wake
    import pmc_pkg::*;
#(
    parameter bit WAKE_OK = 1'b1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  pstate_e state_q,
    input  logic    next_d0,
    input  logic    en_wr,
    input  logic    en_val,
    input  logic    clr_req,
    input  logic    wake_src,
    output logic    wake_en,
    output logic    wake_st
);

    logic low_power;
    logic set_cond;

    assign low_power = (state_q == PS_D1) || (state_q == PS_D2);
    assign set_cond  = WAKE_OK && wake_src && wake_en && low_power;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wake_en <= 1'b0;
        else if (en_wr)
            wake_en <= en_val;
    end

    // Return to D0 clears; a new event wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wake_st <= 1'b0;
        else if (next_d0)
            wake_st <= 1'b0;
        else if (set_cond)
            wake_st <= 1'b1;
        else if (clr_req)
            wake_st <= 1'b0;
    end

endmodule

// File: rtl/pmc_regs.sv
module pmc_regs
    import pmc_pkg::*;
#(
    parameter int         DATA_W   = 32,
    parameter logic [7:0] CAP_ID   = 8'h01,
    parameter logic [7:0] NEXT_PTR = 8'h00,
    parameter bit         D1_OK    = 1'b1,
    parameter bit         D2_OK    = 1'b0,
    parameter bit         WAKE_OK  = 1'b1
) (
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  pstate_e           state_q,
    input  logic              wake_en,
    input  logic              wake_st,
    output logic              ctrl_wr,
    output logic [1:0]        req_code,
    output logic              en_val,
    output logic              clr_req,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cap_word;
    logic [DATA_W-1:0] ctrl_word;
    logic              unused_wdata;

    assign ctrl_wr      = cfg_wr && (cfg_sel == SEL_CTRL);
    assign req_code     = cfg_wdata[STATE_LSB +: 2];
    assign en_val       = cfg_wdata[WAKE_EN_BIT];
    assign clr_req      = ctrl_wr && cfg_wdata[WAKE_ST_BIT];
    assign unused_wdata = ^cfg_wdata;

    always_comb begin
        cap_word                        = '0;
        cap_word[CAP_ID_LSB +: 8]       = CAP_ID;
        cap_word[CAP_NXT_LSB +: 8]      = NEXT_PTR;
        cap_word[CAP_D1_BIT]            = D1_OK;
        cap_word[CAP_D2_BIT]            = D2_OK;
        cap_word[CAP_WAKE_BIT]          = WAKE_OK;
    end

    always_comb begin
        ctrl_word                       = '0;
        ctrl_word[STATE_LSB +: 2]       = state_q;
        ctrl_word[WAKE_EN_BIT]          = wake_en;
        ctrl_word[WAKE_ST_BIT]          = wake_st;
    end

    assign rdata = (cfg_sel == SEL_CTRL) ? ctrl_word : cap_word;

endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
    import pmc_pkg::*;
#(
    parameter int         DATA_W       = 32,
    parameter logic [7:0] CAP_ID       = 8'h01,
    parameter logic [7:0] NEXT_PTR     = 8'h00,
    parameter bit         D1_SUPPORT   = 1'b1,
    parameter bit         D2_SUPPORT   = 1'b0,
    parameter bit         WAKE_SUPPORT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              wake_src,
    output logic [1:0]        pwr_state,
    output logic              clk_gate,
    output logic              func_disable,
    output logic              wake_n
);

    pstate_e    state_q;
    logic       to_d0;
    logic       ctrl_wr;
    logic [1:0] req_code;
    logic       en_val;
    logic       clr_req;
    logic       wake_en;
    logic       wake_st;

    pmc_regs #(
        .DATA_W  (DATA_W),
        .CAP_ID  (CAP_ID),
        .NEXT_PTR(NEXT_PTR),
        .D1_OK   (D1_SUPPORT),
        .D2_OK   (D2_SUPPORT),
        .WAKE_OK (WAKE_SUPPORT)
    ) u_regs (
        .cfg_wr   (cfg_wr),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .state_q  (state_q),
        .wake_en  (wake_en),
        .wake_st  (wake_st),
        .ctrl_wr  (ctrl_wr),
        .req_code (req_code),
        .en_val   (en_val),
        .clr_req  (clr_req),
        .rdata    (cfg_rdata)
    );

    pmc_fsm #(
        .D1_OK(D1_SUPPORT),
        .D2_OK(D2_SUPPORT)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(ctrl_wr),
        .req_code (req_code),
        .state_q  (state_q),
        .to_d0    (to_d0),
        .clk_gate (clk_gate),
        .func_dis (func_disable)
    );

    pmc_wake #(
        .WAKE_OK(WAKE_SUPPORT)
    ) u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_q (state_q),
        .next_d0 (to_d0),
        .en_wr   (ctrl_wr),
        .en_val  (en_val),
        .clr_req (clr_req),
        .wake_src(wake_src),
        .wake_en (wake_en),
        .wake_st (wake_st)
    );

    assign pwr_state = state_q;
    assign wake_n    = ~wake_st;

endmodule

// File: rtl/pmc_ctrl_chk.sv
module pmc_ctrl_chk #(
    parameter bit D1_SUPPORT = 1'b1,
    parameter bit D2_SUPPORT = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_wr,
    input logic       clr_bit,
    input logic       wake_src,
    input logic       wake_en,
    input logic [1:0] pwr_state,
    input logic       clk_gate,
    input logic       func_disable,
    input logic       wake_n
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            past_ok <= 1'b0;
        else
            past_ok <= 1'b1;
    end

    AST_MOVE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && pwr_state != $past(pwr_state)) |-> (pwr_state == 2'd0 || pwr_state > $past(pwr_state))); // R5

    AST_NO_SPONT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(ctrl_wr)) |-> $stable(pwr_state)); // R5

    AST_D1_SUPPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd1) |-> D1_SUPPORT); // R6

    AST_D2_SUPPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd2) |-> D2_SUPPORT); // R6

    AST_D0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0) |-> (wake_n && !func_disable && !clk_gate)); // R11

    AST_GATE_IMPLIES_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        clk_gate |-> func_disable); // R7

    AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $fell(wake_n)) |->
            $past(wake_src && wake_en && (pwr_state == 2'd1 || pwr_state == 2'd2))); // R8

    AST_WAKE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(wake_n)) |-> ($past(ctrl_wr && clr_bit) || pwr_state == 2'd0)); // R10

endmodule

bind pmc_ctrl pmc_ctrl_chk #(
    .D1_SUPPORT(D1_SUPPORT),
    .D2_SUPPORT(D2_SUPPORT)
) i_pmc_ctrl_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_wr     (ctrl_wr),
    .clr_bit     (cfg_wdata[pmc_pkg::WAKE_ST_BIT]),
    .wake_src    (wake_src),
    .wake_en     (wake_en),
    .pwr_state   (pwr_state),
    .clk_gate    (clk_gate),
    .func_disable(func_disable),
    .wake_n      (wake_n)
);

// File: tb/test_pmc_ctrl.sv
`timescale 1ns/1ps
module test_pmc_ctrl;

    localparam int DATA_W = 32;
    localparam bit D1S = 1'b1;
    localparam bit D2S = 1'b0;
    localparam bit WKS = 1'b1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic              cfg_sel = 1'b0;
    logic [DATA_W-1:0] cfg_wdata = '0;
    logic [DATA_W-1:0] cfg_rdata;
    logic              wake_src = 1'b0;
    logic [1:0]        pwr_state;
    logic              clk_gate;
    logic              func_disable;
    logic              wake_n;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // behavioural reference state
    int m_state = 0;
    bit m_en = 1'b0;
    bit m_st = 1'b0;

    always #2 clk = ~clk;

    pmc_ctrl #(
        .DATA_W      (DATA_W),
        .CAP_ID      (8'h01),
        .NEXT_PTR    (8'h00),
        .D1_SUPPORT  (D1S),
        .D2_SUPPORT  (D2S),
        .WAKE_SUPPORT(WKS)
    ) i_pmc_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .wake_src    (wake_src),
        .pwr_state   (pwr_state),
        .clk_gate    (clk_gate),
        .func_disable(func_disable),
        .wake_n      (wake_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // reference model, updated at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_en = 1'b0; m_st = 1'b0;
        end else begin
            int  req;
            int  nxt;
            bit  wr;
            bit  ok;
            bit  setc;
            wr   = cfg_wr && cfg_sel;
            req  = int'(cfg_wdata[1:0]);
            ok   = (req == 0) || ((req > m_state) && (req != 1 || D1S) && (req != 2 || D2S));
            nxt  = (wr && ok) ? req : m_state;
            setc = WKS && wake_src && m_en && (m_state == 1 || m_state == 2);
            if (nxt == 0)                   m_st = 1'b0;
            else if (setc)                  m_st = 1'b1;
            else if (wr && cfg_wdata[15])   m_st = 1'b0;
            if (wr) m_en = cfg_wdata[8];
            m_state = nxt;
        end
    end

    // every-cycle comparison of registered outputs (R7, R9)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7 R9 model compare",
                {28'd0, pwr_state, clk_gate, func_disable, wake_n},
                {28'd0, 2'(m_state), (m_state >= 2), (m_state != 0), !m_st});
        end
    end

    task automatic cfg_write(input logic sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic wake_pulse();
        @(negedge clk);
        wake_src = 1'b1;
        @(negedge clk);
        wake_src = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic sel, input logic [31:0] exp);
        cfg_sel = sel;
        #1;
        chk(tag, cfg_rdata, exp);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 state", {30'd0, pwr_state}, 32'd0);
        chk("R1 wake_n", {31'd0, wake_n}, 32'd1);
        read_chk("R1 ctrl word", 1'b1, 32'h0000_0000);
        // R2 capability word
        read_chk("R2 capability", 1'b0, 32'h0005_0001);
        // R6 unsupported D2 ignored
        cfg_write(1'b1, 32'h0000_0002);
        chk("R6 D2 ignored", {30'd0, pwr_state}, 32'd0);
        // R3 deepen to D1
        cfg_write(1'b1, 32'h0000_0001);
        chk("R3 to D1", {30'd0, pwr_state}, 32'd1);
        chk("R7 D1 outputs", {30'd0, clk_gate, func_disable}, 32'b01);
        // R8 wake disabled -> no event
        wake_pulse();
        chk("R8 wake disabled", {31'd0, wake_n}, 32'd1);
        // R12 enable wake, same state request ignored (R5)
        cfg_write(1'b1, 32'h0000_0101);
        read_chk("R12 wake enable readback", 1'b1, 32'h0000_0101);
        chk("R5 same state kept", {30'd0, pwr_state}, 32'd1);
        // R8 R9 wake event
        wake_pulse();
        chk("R9 wake_n low", {31'd0, wake_n}, 32'd0);
        read_chk("R8 wake status set", 1'b1, 32'h0000_8101);
        // R10 writing 0 to status keeps it
        cfg_write(1'b1, 32'h0000_0101);
        chk("R10 zero write keeps", {31'd0, wake_n}, 32'd0);
        // R10 W1C clears
        cfg_write(1'b1, 32'h0000_8101);
        chk("R10 w1c clears", {31'd0, wake_n}, 32'd1);
        // new event, then D1 -> D3 keeps status
        wake_pulse();
        cfg_write(1'b1, 32'h0000_0103);
        chk("R3 to D3", {30'd0, pwr_state}, 32'd3);
        chk("R7 D3 outputs", {30'd0, clk_gate, func_disable}, 32'b11);
        read_chk("R8 status held in D3", 1'b1, 32'h0000_8103);
        // R5 shallower request ignored in D3
        cfg_write(1'b1, 32'h0000_0101);
        chk("R5 D3 to D1 ignored", {30'd0, pwr_state}, 32'd3);
        // W1C in D3, then wake source in D3 has no effect
        cfg_write(1'b1, 32'h0000_8103);
        chk("R10 w1c in D3", {31'd0, wake_n}, 32'd1);
        wake_pulse();
        chk("R8 no wake in D3", {31'd0, wake_n}, 32'd1);
        // R4 return to D0
        cfg_write(1'b1, 32'h0000_0100);
        chk("R4 D3 to D0", {30'd0, pwr_state}, 32'd0);
        chk("R7 D0 outputs", {30'd0, clk_gate, func_disable}, 32'b00);
        wake_pulse();
        chk("R8 no wake in D0", {31'd0, wake_n}, 32'd1);
        // R11 return to D0 clears status
        cfg_write(1'b1, 32'h0000_0101);
        wake_pulse();
        chk("R11 pre wake set", {31'd0, wake_n}, 32'd0);
        cfg_write(1'b1, 32'h0000_0100);
        chk("R4 D1 to D0", {30'd0, pwr_state}, 32'd0);
        read_chk("R11 status cleared", 1'b1, 32'h0000_0100);
        chk("R11 wake_n released", {31'd0, wake_n}, 32'd1);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule